// File: doc/BRIEF.md
# Big-Endian Partial Load Merge Unit

This unit forms the destination register value for the left and right partial-load operations of a big-endian core. Each request carries an effective address, the aligned memory word or doubleword already fetched, the present contents of the destination register, a direction and a size. The low address bits give a byte offset. Depending on that offset and the direction, some bytes come from memory and the rest keep their old register values. The unit also returns the aligned address, which is the effective address with the offset bits cleared.

Requests enter through a valid/ready handshake. The merged result sits in an output register until the consumer takes it. A request with an unsupported size code produces no result and raises a one-cycle error flag. Doubleword requests work on all 64 bits. Word requests work on the low 32 bits of the memory and register inputs, and the 32-bit merge is sign-extended to 64 bits.

Top module: `plm_top`

## Requirements
- R1: The aligned address on `out_addr` equals `in_addr` with bits [1:0] cleared for a word request (`in_size` = 2'b00) and bits [2:0] cleared for a doubleword request (`in_size` = 2'b01). The cleared bits are the byte offset n.
- R2: Word left (`in_dir` = 0) with offset n returns `in_mem[31:0]` shifted left by 8·n bits, with the low n bytes taken from `in_old[31:0]`. At n = 0 the whole word comes from memory.
- R3: Word right (`in_dir` = 1) with offset n places the upper n+1 bytes of `in_mem[31:0]` in the low bytes, which is a right shift by 8·(3−n). The remaining upper bytes come from `in_old[31:0]`. At n = 3 the whole word comes from memory.
- R4: Doubleword left with offset n returns `in_mem` shifted left by 8·n bits, with the low n bytes taken from `in_old`. At n = 0 the result is `in_mem`.
- R5: Doubleword right with offset n returns `in_mem` shifted right by 8·(7−n) bits, with the upper 7−n bytes taken from `in_old`. At n = 7 the result is `in_mem`.
- R6: For a word request, `out_data[63:32]` copies bit 31 of the merged word, and `in_old[63:32]` has no effect.
- R7: `in_ready` is high when `out_valid` is low or `out_ready` is high. A request is accepted when `in_valid` and `in_ready` are both high, and `out_valid` rises on the next clock edge.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_addr` hold their values.
- R9: An accepted request with `in_size[1]` = 1 does not raise `out_valid`, and it raises `out_err` for exactly the cycle after acceptance.
- R10: After reset, `out_valid` and `out_err` are low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Unit can accept a request |
| in_addr | input | 32 | Effective byte address |
| in_mem | input | 64 | Aligned memory data, big-endian |
| in_old | input | 64 | Current destination register value |
| in_dir | input | 1 | 0 = left merge, 1 = right merge |
| in_size | input | 2 | 00 = word, 01 = doubleword, 1x = invalid |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 64 | Merged register value |
| out_addr | output | 32 | Aligned access address |
| out_err | output | 1 | One-cycle pulse for an invalid size code |

## Verification
A directed sweep covers every offset in both directions at both sizes. Memory and register values are random, with all bytes distinct, so a byte taken from the wrong lane or from the wrong source shows up as a mismatch. Extra word requests put a set bit 31 together with random upper old bits, which separates sign extension from passing the old upper half through. A random phase mixes all combinations, then one stalled request shows the output holds while the consumer is not ready and shows back-pressure on `in_ready`, and the invalid size codes show the error pulse and the missing result.

// File: rtl/plm_pkg.sv
package plm_pkg;
    localparam logic [1:0] PLM_SZ_WORD  = 2'b00;
    localparam logic [1:0] PLM_SZ_DWORD = 2'b01;
    localparam logic       PLM_DIR_LEFT  = 1'b0;
    localparam logic       PLM_DIR_RIGHT = 1'b1;
    localparam int unsigned PLM_WORD_LANES = 4;
endpackage

// File: rtl/plm_addr_split.sv
module plm_addr_split #(
    parameter int unsigned AW = 32
) (
    input  logic [AW-1:0] addr,
    input  logic          dword,
    output logic [AW-1:0] aligned,
    output logic [2:0]    offset
);
    logic [2:0] keep_mask;

    always_comb begin
        keep_mask = dword ? 3'b111 : 3'b011;
        offset    = addr[2:0] & keep_mask;
        aligned   = {addr[AW-1:3], addr[2:0] & ~keep_mask};
    end

    always_comb begin
        if (!dword) assert (offset[2] == 1'b0)
            else $error("p_word_offset_r1: word offset exceeds 3");
    end
endmodule

// File: rtl/plm_lane_merge.sv
module plm_lane_merge #(
    parameter int unsigned LANES = 8
) (
    input  logic [LANES*8-1:0]         mem,
    input  logic [LANES*8-1:0]         old,
    input  logic [$clog2(LANES)-1:0]   off,
    input  logic                       right,
    output logic [LANES*8-1:0]         res
);
    localparam int unsigned IW = $clog2(LANES);

    logic [7:0] mem_b [LANES];
    logic [7:0] old_b [LANES];

    genvar gi;
    generate
        for (gi = 0; gi < LANES; gi++) begin : g_lane
            localparam logic [IW-1:0] LI = IW'(gi);
            logic [IW-1:0] sel_l;
            logic [IW-1:0] sel_r;
            logic          take_l;
            logic          take_r;

            assign mem_b[gi] = mem[gi*8 +: 8];
            assign old_b[gi] = old[gi*8 +: 8];

            always_comb begin
                sel_l  = LI - off;
                sel_r  = ~(off - LI);
                take_l = (off <= LI);
                take_r = (LI <= off);
                if (!right) res[gi*8 +: 8] = take_l ? mem_b[sel_l] : old_b[gi];
                else        res[gi*8 +: 8] = take_r ? mem_b[sel_r] : old_b[gi];
            end
        end
    endgenerate

    always_comb begin
        if (!right && off == '0)
            assert (res == mem) else $error("p_full_left_r4: left offset 0 not full load");
        if (right && off == {IW{1'b1}})
            assert (res == mem) else $error("p_full_right_r5: right top offset not full load");
        if (!right)
            assert (res[7:0] == ((off == '0) ? mem[7:0] : old[7:0]))
                else $error("p_left_lsb_r2: lowest byte source wrong");
    end
endmodule

// File: rtl/plm_top.sv
module plm_top #(
    parameter int unsigned AW   = 32,
    parameter int unsigned XLEN = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    output logic            in_ready,
    input  logic [AW-1:0]   in_addr,
    input  logic [XLEN-1:0] in_mem,
    input  logic [XLEN-1:0] in_old,
    input  logic            in_dir,
    input  logic [1:0]      in_size,
    output logic            out_valid,
    input  logic            out_ready,
    output logic [XLEN-1:0] out_data,
    output logic [AW-1:0]   out_addr,
    output logic            out_err
);
    import plm_pkg::*;

    localparam int unsigned DW_LANES = XLEN / 8;
    localparam int unsigned WL       = PLM_WORD_LANES;
    localparam int unsigned WBITS    = WL * 8;

    typedef struct packed {
        logic            vld;
        logic            err;
        logic            dw;
        logic [XLEN-1:0] data;
        logic [AW-1:0]   addr;
    } plm_state_t;

    plm_state_t st_d, st_q;

    logic            is_dw;
    logic            bad_size;
    logic            accept;
    logic [AW-1:0]   aligned;
    logic [2:0]      offset;
    logic [XLEN-1:0] dw_res;
    logic [WBITS-1:0] w_res;
    logic [XLEN-1:0] merged;

    assign is_dw    = (in_size == PLM_SZ_DWORD);
    assign bad_size = in_size[1];

    plm_addr_split #(.AW(AW)) u_split (
        .addr    (in_addr),
        .dword   (is_dw),
        .aligned (aligned),
        .offset  (offset)
    );

    plm_lane_merge #(.LANES(DW_LANES)) u_dw (
        .mem   (in_mem),
        .old   (in_old),
        .off   (offset[$clog2(DW_LANES)-1:0]),
        .right (in_dir),
        .res   (dw_res)
    );

    plm_lane_merge #(.LANES(WL)) u_w (
        .mem   (in_mem[WBITS-1:0]),
        .old   (in_old[WBITS-1:0]),
        .off   (offset[$clog2(WL)-1:0]),
        .right (in_dir),
        .res   (w_res)
    );

    always_comb begin
        in_ready = !st_q.vld || out_ready;
        accept   = in_valid && in_ready;
        merged   = is_dw ? dw_res : {{(XLEN-WBITS){w_res[WBITS-1]}}, w_res};

        st_d     = st_q;
        st_d.err = 1'b0;
        if (st_q.vld && out_ready) st_d.vld = 1'b0;
        if (accept) begin
            if (bad_size) begin
                st_d.err = 1'b1;
            end else begin
                st_d.vld  = 1'b1;
                st_d.dw   = is_dw;
                st_d.data = merged;
                st_d.addr = aligned;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign out_data  = st_q.data;
    assign out_addr  = st_q.addr;
    assign out_err   = st_q.err;

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_addr)));
    p_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && !in_size[1]) |=> out_valid);
    p_err_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_err |-> $past(in_valid && in_ready && in_size[1]));
    p_err_noout_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_err |-> !$rose(out_valid));
    p_sext_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !st_q.dw) |-> (out_data[XLEN-1:WBITS] == {(XLEN-WBITS){out_data[WBITS-1]}}));
    p_align_r1: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_addr[1:0] == 2'b00 && (!st_q.dw || !out_addr[2])));
endmodule

// File: tb/tb_plm_top.sv
module tb_plm_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_addr = '0;
    logic [63:0] in_mem = '0;
    logic [63:0] in_old = '0;
    logic        in_dir = 1'b0;
    logic [1:0]  in_size = 2'b00;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [63:0] out_data;
    logic [31:0] out_addr;
    logic        out_err;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 0;

    always #5 clk = ~clk;

    plm_top dut (.*);

    function automatic logic [63:0] ref_merge(input logic [31:0] a, input logic [63:0] m,
                                              input logic [63:0] o, input logic d, input logic dw);
        int w;
        int n;
        logic [63:0] mw, ow, mask, r;
        w  = dw ? 8 : 4;
        n  = dw ? int'(a[2:0]) : int'(a[1:0]);
        mw = dw ? m : {32'h0, m[31:0]};
        ow = dw ? o : {32'h0, o[31:0]};
        if (!d) begin
            mask = (64'h1 << (8*n)) - 64'h1;
            r = (mw << (8*n)) | (ow & mask);
        end else begin
            mask = (n == 7) ? 64'h0 : ~((64'h1 << (8*(n+1))) - 64'h1);
            if (!dw) mask = mask & 64'hFFFF_FFFF;
            r = (mw >> (8*(w-1-n))) | (ow & mask);
        end
        if (!dw) r = {{32{r[31]}}, r[31:0]};
        return r;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic run_req(input string req, input logic [31:0] a, input logic [63:0] m,
                           input logic [63:0] o, input logic d, input logic [1:0] sz);
        logic [31:0] ea;
        @(negedge clk);
        in_addr = a; in_mem = m; in_old = o; in_dir = d; in_size = sz; in_valid = 1'b1;
        check("R7 ready", {63'h0, in_ready}, 64'h1);
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        if (sz[1]) begin
            check("R9 err pulse", {63'h0, out_err}, 64'h1);
            check("R9 no result", {63'h0, out_valid}, 64'h0);
        end else begin
            ea = sz[0] ? {a[31:3], 3'b000} : {a[31:2], 2'b00};
            check("R7 valid", {63'h0, out_valid}, 64'h1);
            check(req, out_data, ref_merge(a, m, o, d, sz[0]));
            check("R1 addr", {32'h0, out_addr}, {32'h0, ea});
        end
    endtask

    function automatic logic [63:0] distinct_bytes(input int seed);
        logic [63:0] v;
        for (int b = 0; b < 8; b++) v[b*8 +: 8] = 8'((seed * 8 + b) * 37 + 11);
        return v;
    endfunction

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (2) @(negedge clk);
        check("R10 valid", {63'h0, out_valid}, 64'h0);
        check("R10 err", {63'h0, out_err}, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 ready", {63'h0, in_ready}, 64'h1);

        for (int n = 0; n < 4; n++) begin
            run_req("R2 word left", 32'h1000_0000 | 32'(n), distinct_bytes(n), distinct_bytes(n+20), 1'b0, 2'b00);
            run_req("R3 word right", 32'h2000_0004 | 32'(n), distinct_bytes(n+5), distinct_bytes(n+30), 1'b1, 2'b00);
            run_req("R6 word sext", 32'h0000_0100 | 32'(n), 64'h1234_5678_F1E2_D3C4, {$urandom(), $urandom()}, 1'b0, 2'b00);
            run_req("R6 word sext right", 32'h0000_0100 | 32'(n), 64'hAAAA_BBBB_F1E2_D3C4, 64'h5555_6666_8899_AABB, 1'b1, 2'b00);
        end
        for (int n = 0; n < 8; n++) begin
            run_req("R4 dword left", 32'h3000_0000 | 32'(n), distinct_bytes(n+40), distinct_bytes(n+60), 1'b0, 2'b01);
            run_req("R5 dword right", 32'h4000_0000 | 32'(n), distinct_bytes(n+80), distinct_bytes(n+99), 1'b1, 2'b01);
        end
        for (int i = 0; i < 300; i++) begin
            logic [1:0] sz;
            sz = 2'($urandom_range(0, 1));
            run_req(sz[0] ? "R4/R5 random dword" : "R2/R3 random word", $urandom(),
                    {$urandom(), $urandom()}, {$urandom(), $urandom()}, 1'($urandom()), sz);
        end

        @(negedge clk);
        out_ready = 1'b0;
        in_addr = 32'h5; in_mem = distinct_bytes(7); in_old = distinct_bytes(9);
        in_dir = 1'b0; in_size = 2'b01; in_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        begin
            logic [63:0] held;
            held = out_data;
            check("R7 ready low", {63'h0, in_ready}, 64'h0);
            repeat (3) @(negedge clk);
            check("R8 hold valid", {63'h0, out_valid}, 64'h1);
            check("R8 hold data", out_data, held);
            check("R4 stalled data", held, ref_merge(32'h5, distinct_bytes(7), distinct_bytes(9), 1'b0, 1'b1));
        end
        out_ready = 1'b1;
        @(negedge clk);
        check("R7 drained", {63'h0, out_valid}, 64'h0);

        run_req("R9", 32'h7, 64'h1, 64'h2, 1'b0, 2'b10);
        run_req("R9", 32'h3, 64'h1, 64'h2, 1'b1, 2'b11);
        @(negedge clk);
        check("R9 err one cycle", {63'h0, out_err}, 64'h0);

        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule